// File: doc/BRIEF.md
# System Reset Initialisation Sequencer

This block carries out the work that follows a system reset request. In the cycle the request is sampled it drops every pending interrupt and every error flag, clears the instruction address, places the processor in the stopped state and sends a one-cycle reset pulse to the channels. It then runs a store walk. First it rewrites every entry of the local register file with a zero word that carries correct parity. Then it fills the subchannel control area of storage, four words for each subchannel. All writes use simple write ports and are issued one per clock. A one-cycle done flag marks the end of the walk.

Parity is odd and is kept per byte. Every write carries four parity bits, and bit i covers byte i, which is data bits 8i+7 down to 8i. A new request that arrives during a walk starts the whole sequence again. Interrupts and errors that are raised after the request has been sampled are kept. A fault seen during the initialisation is therefore still visible when it ends. While the walk runs, the start control and the instruction-address load are ignored.

Top module: `sysrst_seq`

## Requirements
- R1: In the cycle after `sys_req` is sampled high, `stopped`=1, `iar`=0, `irq_pend`=0, `err_flags`=0 and `chan_rst`=1. `chan_rst` is high for that single cycle only.
- R2: Bits set through `irq_set` or `err_set` in any cycle after the request cycle stay set, and they are still visible once `done` has been seen.
- R3: Cycles 2 to LS_DEPTH+1 after the request carry one local-file write per cycle (`ls_we`=1) at addresses 0 to LS_DEPTH-1 in ascending order. Each write has `ls_wdata`=0 and `ls_wpar`=4'hF.
- R4: The next 4·NSUB cycles carry one storage write per cycle at SC_BASE+k for k = 0 to 4·NSUB-1. When k mod 4 = 0 the write has data 0 and parity 4'hF. For any other k it has data 32'h07000000 and parity 4'b0111.
- R5: `done` is high for exactly one cycle, the cycle of the last storage write. `busy` is high from the cycle after the request up to the cycle before `done`.
- R6: A `sys_req` sampled during a walk restarts the whole sequence, and R1, R3 and R4 then apply from that request.
- R7: While `busy`=1, `start` and `iar_ld` have no effect. When the block is idle, `start` clears `stopped` and `iar_ld` loads `iar_din` into `iar`, each effective in the next cycle.
- R8: After `rst`, `stopped`=1, `iar`=0, `irq_pend`=0, `err_flags`=0, `busy`=0, and no write enable is active.
- R9: `ls_we` and `st_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sys_req | input | 1 | System reset request |
| irq_set | input | NIRQ | Interrupt raise strobes |
| err_set | input | NERR | Error raise strobes |
| start | input | 1 | Leave stopped state (idle only) |
| iar_ld | input | 1 | Load instruction address (idle only) |
| iar_din | input | IAR_W | Instruction address to load |
| irq_pend | output | NIRQ | Pending interrupts |
| err_flags | output | NERR | Error indicators |
| iar | output | IAR_W | Instruction address register |
| stopped | output | 1 | Processor stopped state |
| chan_rst | output | 1 | One-cycle channel reset pulse |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk complete pulse |
| ls_we | output | 1 | Local file write enable |
| ls_addr | output | LS_AW | Local file write address |
| ls_wdata | output | 32 | Local file write data |
| ls_wpar | output | 4 | Local file write parity |
| st_we | output | 1 | Storage write enable |
| st_addr | output | ADDR_W | Storage write address |
| st_wdata | output | 32 | Storage write data |
| st_wpar | output | 4 | Storage write parity |

## Verification
The hardest case to reach from the ports is a second request that lands partway through a walk, since the restart point can fall anywhere in either phase. The bench sweeps the interruption point over every cycle of a small walk (LS_DEPTH=4, NSUB=3). After each interruption it checks the whole restarted sequence write by write against addresses and patterns computed arithmetically. Errors, interrupts, start and address loads are injected inside the walk, and their final state is read at the ports.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
  localparam int WORD_W = 32;
  localparam int NBYTES = WORD_W / 8;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NBYTES-1:0] par_t;
  localparam word_t SC_FILL = 32'h0700_0000;

  // odd parity per byte: bit i makes byte i plus parity hold an odd count of ones
  function automatic par_t odd_par(input word_t w);
    par_t p;
    for (int i = 0; i < NBYTES; i++) p[i] = ~(^w[8*i +: 8]);
    return p;
  endfunction
endpackage

// File: rtl/sysrst_ctl.sv
module sysrst_ctl #(
  parameter int TOTAL = 16,
  localparam int CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_req,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             done,
  output logic             chan_rst
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
      chan_rst <= 1'b0;
    end else begin
      done     <= 1'b0;
      chan_rst <= 1'b0;
      if (sys_req) begin
        busy     <= 1'b1;
        cnt      <= '0;
        chan_rst <= 1'b1;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sysrst_wgen.sv
module sysrst_wgen
  import sysrst_pkg::*;
#(
  parameter int LS_DEPTH = 64,
  parameter int TOTAL    = 128,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SC_BASE = '0,
  localparam int CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int LS_AW = (LS_DEPTH > 1) ? $clog2(LS_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [CNT_W-1:0]  cnt,
  output logic              ls_we,
  output logic [LS_AW-1:0]  ls_addr,
  output word_t             ls_wdata,
  output par_t              ls_wpar,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output word_t             st_wdata,
  output par_t              st_wpar
);
  localparam logic [CNT_W-1:0] LS_END = CNT_W'(LS_DEPTH);

  logic             in_ls;
  logic [CNT_W-1:0] sc_off;
  word_t            sc_word;

  always_comb begin
    in_ls   = (cnt < LS_END);
    sc_off  = cnt - LS_END;
    sc_word = (sc_off[1:0] == 2'd0) ? '0 : SC_FILL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ls_we <= 1'b0;
      st_we <= 1'b0;
    end else begin
      ls_we <= step && in_ls;
      st_we <= step && !in_ls;
    end
  end

  always_ff @(posedge clk) begin
    ls_addr  <= LS_AW'(cnt);
    ls_wdata <= '0;
    ls_wpar  <= odd_par('0);
    st_addr  <= SC_BASE + ADDR_W'(sc_off);
    st_wdata <= sc_word;
    st_wpar  <= odd_par(sc_word);
  end
endmodule

// File: rtl/sysrst_status.sv
module sysrst_status #(
  parameter int NIRQ  = 8,
  parameter int NERR  = 8,
  parameter int IAR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sys_req,
  input  logic             busy,
  input  logic [NIRQ-1:0]  irq_set,
  input  logic [NERR-1:0]  err_set,
  input  logic             start,
  input  logic             iar_ld,
  input  logic [IAR_W-1:0] iar_din,
  output logic [NIRQ-1:0]  irq_pend,
  output logic [NERR-1:0]  err_flags,
  output logic [IAR_W-1:0] iar,
  output logic             stopped
);
  always_ff @(posedge clk) begin
    if (rst || sys_req) begin
      irq_pend  <= '0;
      err_flags <= '0;
      iar       <= '0;
      stopped   <= 1'b1;
    end else begin
      irq_pend  <= irq_pend | irq_set;
      err_flags <= err_flags | err_set;
      if (!busy) begin
        if (start)  stopped <= 1'b0;
        if (iar_ld) iar     <= iar_din;
      end
    end
  end
endmodule

// File: rtl/sysrst_seq.sv
module sysrst_seq
  import sysrst_pkg::*;
#(
  parameter int LS_DEPTH = 64,
  parameter int NSUB     = 16,
  parameter int ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SC_BASE = 16'h0100,
  parameter int NIRQ     = 8,
  parameter int NERR     = 8,
  parameter int IAR_W    = 24,
  localparam int TOTAL   = LS_DEPTH + 4 * NSUB,
  localparam int CNT_W   = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int LS_AW   = (LS_DEPTH > 1) ? $clog2(LS_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_req,
  input  logic [NIRQ-1:0]   irq_set,
  input  logic [NERR-1:0]   err_set,
  input  logic              start,
  input  logic              iar_ld,
  input  logic [IAR_W-1:0]  iar_din,
  output logic [NIRQ-1:0]   irq_pend,
  output logic [NERR-1:0]   err_flags,
  output logic [IAR_W-1:0]  iar,
  output logic              stopped,
  output logic              chan_rst,
  output logic              busy,
  output logic              done,
  output logic              ls_we,
  output logic [LS_AW-1:0]  ls_addr,
  output logic [31:0]       ls_wdata,
  output logic [3:0]        ls_wpar,
  output logic              st_we,
  output logic [ADDR_W-1:0] st_addr,
  output logic [31:0]       st_wdata,
  output logic [3:0]        st_wpar
);
  logic [CNT_W-1:0] cnt;

  sysrst_ctl #(.TOTAL(TOTAL)) ctl_i (
    .clk(clk), .rst(rst), .sys_req(sys_req),
    .busy(busy), .cnt(cnt), .done(done), .chan_rst(chan_rst)
  );

  sysrst_wgen #(
    .LS_DEPTH(LS_DEPTH), .TOTAL(TOTAL), .ADDR_W(ADDR_W), .SC_BASE(SC_BASE)
  ) wgen_i (
    .clk(clk), .rst(rst || sys_req), .step(busy), .cnt(cnt),
    .ls_we(ls_we), .ls_addr(ls_addr), .ls_wdata(ls_wdata), .ls_wpar(ls_wpar),
    .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata), .st_wpar(st_wpar)
  );

  sysrst_status #(.NIRQ(NIRQ), .NERR(NERR), .IAR_W(IAR_W)) status_i (
    .clk(clk), .rst(rst), .sys_req(sys_req), .busy(busy),
    .irq_set(irq_set), .err_set(err_set), .start(start),
    .iar_ld(iar_ld), .iar_din(iar_din),
    .irq_pend(irq_pend), .err_flags(err_flags), .iar(iar), .stopped(stopped)
  );
endmodule

// File: rtl/sysrst_seq_chk.sv
module sysrst_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int IAR_W  = 24,
  parameter int NIRQ   = 8,
  parameter int NERR   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sys_req,
  input logic              start,
  input logic              iar_ld,
  input logic [NIRQ-1:0]   irq_pend,
  input logic [NERR-1:0]   err_flags,
  input logic [IAR_W-1:0]  iar,
  input logic              stopped,
  input logic              chan_rst,
  input logic              busy,
  input logic              done,
  input logic              ls_we,
  input logic              st_we,
  input logic [ADDR_W-1:0] st_addr,
  input logic [31:0]       st_wdata
);
  // R1
  clear_on_req_chk: assert property (@(posedge clk) disable iff (rst)
    sys_req |=> (stopped && iar == '0 && irq_pend == '0 && err_flags == '0 && chan_rst));
  // R1
  chan_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_rst && !sys_req) |=> !chan_rst);
  // R4
  sc_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (st_wdata == 32'h0 || st_wdata == 32'h0700_0000));
  // R4
  sc_ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (st_we && $past(st_we) && !$past(sys_req, 2)) |-> st_addr == $past(st_addr) + 1'b1);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  done_last_write_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (st_we && !busy));
  // R7
  iar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !sys_req) |=> $stable(iar));
  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && stopped && !sys_req) |=> stopped);
  // R9
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    !(ls_we && st_we));
endmodule

bind sysrst_seq sysrst_seq_chk #(
  .ADDR_W(ADDR_W), .IAR_W(IAR_W), .NIRQ(NIRQ), .NERR(NERR)
) chk_i (
  .clk(clk), .rst(rst), .sys_req(sys_req), .start(start), .iar_ld(iar_ld),
  .irq_pend(irq_pend), .err_flags(err_flags), .iar(iar), .stopped(stopped),
  .chan_rst(chan_rst), .busy(busy), .done(done), .ls_we(ls_we),
  .st_we(st_we), .st_addr(st_addr), .st_wdata(st_wdata)
);

// File: tb/sysrst_seq_tb.sv
module sysrst_seq_tb_top;
  localparam int LSD = 4;
  localparam int NS = 3;
  localparam int AW = 8;
  localparam logic [AW-1:0] BASE = 8'h40;
  localparam int TOT = LSD + 4 * NS;
  localparam int IW = 12;

  logic clk = 0, rst = 1, sys_req = 0, start = 0, iar_ld = 0;
  logic [3:0] irq_set = 0, err_set = 0;
  logic [IW-1:0] iar_din = 0;
  logic [3:0] irq_pend, err_flags;
  logic [IW-1:0] iar;
  logic stopped, chan_rst, busy, done, ls_we, st_we;
  logic [1:0] ls_addr;
  logic [AW-1:0] st_addr;
  logic [31:0] ls_wdata, st_wdata;
  logic [3:0] ls_wpar, st_wpar;
  int errors = 0, checks = 0, cyc = 0;

  sysrst_seq #(.LS_DEPTH(LSD), .NSUB(NS), .ADDR_W(AW), .SC_BASE(BASE),
               .NIRQ(4), .NERR(4), .IAR_W(IW)) dut_i (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [3:0] opar(input logic [31:0] w);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) begin
      int ones = 0;
      for (int j = 0; j < 8; j++) ones += w[8*b+j];
      p[b] = (ones % 2 == 0);
    end
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // state one cycle after request sampled (R1)
  task automatic chk_clear();
    chk("R1 clear", {stopped, iar, irq_pend, err_flags, chan_rst, busy, ls_we, st_we},
        {1'b1, {IW{1'b0}}, 4'h0, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0});
  endtask

  // one cycle n (1..TOT+1) of the walk: R3, R4, R5, R9
  task automatic chk_cycle(input int n);
    logic e_ls, e_st;
    logic [31:0] d;
    int k;
    e_ls = (n >= 1 && n <= LSD);
    e_st = (n > LSD && n <= TOT);
    chk("R5 busy/done/chan", {busy, done, chan_rst}, {n < TOT, n == TOT, 1'b0});
    chk("R9 enables", {ls_we, st_we}, {e_ls, e_st});
    if (e_ls) chk("R3 local write", {ls_addr, ls_wdata, ls_wpar},
                  {2'(n - 1), 32'h0, 4'hF});
    if (e_st) begin
      k = n - 1 - LSD;
      d = (k % 4 == 0) ? 32'h0 : 32'h0700_0000;
      chk("R4 storage write", {st_addr, st_wdata, st_wpar},
          {BASE + AW'(k), d, opar(d)});
    end
  endtask

  task automatic request();
    @(negedge clk); sys_req = 1;
    @(negedge clk); sys_req = 0;
    chk_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R8
    chk("R8 reset state", {stopped, iar, irq_pend, err_flags, busy, ls_we, st_we, done},
        {1'b1, {IW{1'b0}}, 8'h0, 4'b0000});
    // R7 idle accepts start and address load
    start = 1; iar_ld = 1; iar_din = 12'h5A3; irq_set = 4'h3; err_set = 4'hC;
    @(negedge clk); start = 0; iar_ld = 0; irq_set = 0; err_set = 0;
    chk("R7 idle accept", {stopped, iar}, {1'b0, 12'h5A3});
    // R1 clears everything set before
    request();
    // full walk with injections: R2, R7
    for (int n = 1; n <= TOT + 1; n++) begin
      @(negedge clk);
      chk_cycle(n);
      irq_set = 0; err_set = 0; start = 0; iar_ld = 0;
      if (n == 2) begin start = 1; iar_ld = 1; iar_din = 12'h777; end
      if (n == 3) err_set = 4'h2;
      if (n == LSD + 2) irq_set = 4'h8;
    end
    chk("R2 errors kept", {err_flags, irq_pend}, {4'h2, 4'h8});
    chk("R7 busy ignored", {stopped, iar}, {1'b1, 12'h000});
    // R6 restart at every point of the walk
    for (int k = 1; k <= TOT; k++) begin
      request();
      for (int n = 1; n <= k; n++) begin
        @(negedge clk);
        chk_cycle(n);
      end
      sys_req = 1;
      @(negedge clk); sys_req = 0;
      chk_clear();
      for (int n = 1; n <= TOT + 1; n++) begin
        @(negedge clk);
        chk_cycle(n);
      end
      chk("R6 restart complete", {busy, ls_we, st_we}, 3'b000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule